// File: doc/BRIEF.md
# Lock-Step Neural Evaluation Lane Array

This block is a small array of SIMD lanes. Each lane normally idles in precise mode and can switch into a neural mode. In neural mode every lane runs the same small multilayer perceptron on its own input values. All lanes step together, one neuron at a time. A single weight stream is written once into a shared weight queue. Every lane takes the head weight in the same cycle, so the lanes never drift apart.

Software-side code pushes one value per lane with a send strobe, then pulses start. It streams the weights and pops one result per lane with a receive strobe for every output neuron. Each lane has an input queue, an output queue, a 32-bit accumulator and a multiply-add unit that it reuses for every product. It also has a 64-entry sigmoid table and a pair of small activation buffers. These buffers hand the outputs of one layer to the next layer as its inputs. A single controller sequences loading, multiply-accumulate, activation and layer turnover for all lanes.

Top module: `nl_array`

## Requirements
- R1: After reset, `neural_mode_o`, `done_o`, `recv_valid_o`, `w_full_o` and `send_full_o` are all low.
- R2: A neuron's value is computed in three steps. First the accumulator adds up the signed Q8.8 weight-times-input products, each product in Q16.16, in a 32-bit register. The sum is then shifted right arithmetically by 8 and saturated to the signed 16-bit range. Finally it passes through the sigmoid.
- R3: The sigmoid takes a Q8.8 value x. If x < -2048 the result is 0, and if x > 2047 the result is 256. Otherwise the index k = (x+2048)>>6 (0..63) selects round(256/(1+e^-m)), where m = -8 + 0.25k + 0.125.
- R4: The weight queue is shared. Each weight is used by every lane in the same cycle, so lanes with different inputs give results from identical weights, and their queues fill and drain together.
- R5: Weights are consumed layer by layer, then neuron by neuron, then input by input. The outputs of each layer become the inputs of the next layer, and only the last layer's outputs reach the output queues.
- R6: The topology is captured when start is accepted. `cfg_layers_i` sets 1..3 computing layers, `cfg_inputs_i` sets 1..8 inputs, and `cfg_neurons_i` holds 4 bits per layer, with layer 0 in bits [3:0], giving 1..8 neurons each. Changing these inputs during a run has no effect on that run.
- R7: `send_i` pushes the lane's 16-bit slice of `send_data_i`, where lane l uses bits [16l+15:16l], into each input queue. `send_full_o` is high while the input queues are full. `recv_i` pops one result per lane, and `recv_valid_o` is high while every output queue holds a result.
- R8: `start_i` while idle raises `neural_mode_o` and clears `done_o`. When the last output neuron is written, `neural_mode_o` falls and `done_o` rises. `done_o` stays high until the next start. `start_i` during a run is ignored.
- R9: Multiply-accumulate steps stall while the weight queue is empty. No result appears until the weights arrive, and late weights give the same results.
- R10: Activation of an output neuron stalls while any output queue is full. The block stays in neural mode and no result is lost.
- R11: Input loading stalls while any input queue is empty, so inputs may be sent after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Enter neural mode and begin an evaluation |
| cfg_layers_i | input | 2 | Number of computing layers (1..3) |
| cfg_inputs_i | input | 4 | Number of network inputs (1..8) |
| cfg_neurons_i | input | 12 | Neurons per layer, 4 bits each |
| w_push_i | input | 1 | Push one weight into the shared queue |
| w_data_i | input | 16 | Weight, signed Q8.8 |
| w_full_o | output | 1 | Shared weight queue is full |
| send_i | input | 1 | Push one input value into every lane |
| send_data_i | input | 64 | Per-lane input values, signed Q8.8 |
| send_full_o | output | 1 | Input queues are full |
| recv_i | input | 1 | Pop one result from every lane |
| recv_data_o | output | 64 | Per-lane head results, Q8.8 in 0..256 |
| recv_valid_o | output | 1 | Every output queue holds a result |
| neural_mode_o | output | 1 | Lanes are evaluating the network |
| done_o | output | 1 | Last evaluation finished |

## Verification
The lock-step assertion assumes that sends and receives always reach every lane together, which the shared strobes guarantee. It also assumes that no send is issued while `send_full_o` is high and no weight push while `w_full_o` is high. The stimulus gates every weight push on `w_full_o` and only sends while the input queues have room. It uses topologies within the configured limits, and it keeps weights and inputs small enough that the 32-bit accumulator never wraps.

// File: rtl/nl_pkg.sv
package nl_pkg;
  localparam int FRAC = 8;  // Q8.8 data; sigmoid table is built for this

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MAC,
    ST_ACT,
    ST_NEXT
  } nl_state_e;
endpackage

// File: rtl/nl_fifo.sv
module nl_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [AW:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      if (do_push && !do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nl_alu.sv
module nl_alu #(
  parameter int DW   = 16,
  parameter int ACCW = 32
) (
  input  logic signed [DW-1:0]   a_i,
  input  logic signed [DW-1:0]   b_i,
  input  logic signed [ACCW-1:0] c_i,
  output logic signed [ACCW-1:0] y_o
);
  logic signed [2*DW-1:0] prod;
  assign prod = a_i * b_i;
  assign y_o  = c_i + ACCW'(prod);
endmodule

// File: rtl/nl_sigmoid.sv
module nl_sigmoid import nl_pkg::*; #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] x_i,
  output logic [DW-1:0]        y_o
);
  localparam int LIM = 8 << FRAC;
  localparam int ONE = 1 << FRAC;
  localparam int SH  = FRAC - 2;  // 64 bins over [-8,8)

  // upper half, bins 32..63; lower half mirrors as ONE - value
  function automatic int pos_val(input logic [4:0] m);
    case (m)
      5'd0:  return 136; 5'd1:  return 152; 5'd2:  return 167; 5'd3:  return 181;
      5'd4:  return 193; 5'd5:  return 204; 5'd6:  return 214; 5'd7:  return 222;
      5'd8:  return 229; 5'd9:  return 234; 5'd10: return 239; 5'd11: return 242;
      5'd12: return 245; 5'd13: return 248; 5'd14: return 249; 5'd15: return 251;
      5'd16: return 252; 5'd17: return 253; 5'd18: return 254; 5'd19: return 254;
      5'd20: return 254; 5'd21: return 255; 5'd22: return 255; 5'd23: return 255;
      5'd24: return 255;
      default: return 256;
    endcase
  endfunction

  int off;
  logic [5:0] idx;

  always_comb begin
    off = int'(x_i) + LIM;
    idx = 6'(off >>> SH);
    if (off < 0)             y_o = '0;
    else if (off >= 2 * LIM) y_o = DW'(ONE);
    else if (idx[5])         y_o = DW'(pos_val(idx[4:0]));
    else                     y_o = DW'(ONE - pos_val(5'd31 - idx[4:0]));
  end
endmodule

// File: rtl/nl_lane.sv
module nl_lane import nl_pkg::*; #(
  parameter int DW        = 16,
  parameter int ACCW      = 32,
  parameter int MAXN      = 8,
  parameter int IN_DEPTH  = 8,
  parameter int OUT_DEPTH = 4,
  localparam int IDXW     = $clog2(MAXN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            send_i,
  input  logic [DW-1:0]   send_data_i,
  input  logic            recv_i,
  output logic [DW-1:0]   recv_data_o,
  output logic            in_empty_o,
  output logic            in_full_o,
  output logic            out_empty_o,
  output logic            out_full_o,
  input  logic            ld_i,
  input  logic            mac_i,
  input  logic            act_i,
  input  logic            act_out_i,
  input  logic            swap_i,
  input  logic            clr_i,
  input  logic [IDXW-1:0] in_idx_i,
  input  logic [IDXW-1:0] nrn_idx_i,
  input  logic [DW-1:0]   w_i
);
  localparam logic signed [ACCW-1:0] HI = ACCW'((1 << (DW-1)) - 1);
  localparam logic signed [ACCW-1:0] LO = -HI - 1;

  logic [DW-1:0] src_q [MAXN];
  logic [DW-1:0] dst_q [MAXN];
  logic signed [ACCW-1:0] acc_q, mac_y, acc_sh;
  logic signed [DW-1:0] xq;
  logic [DW-1:0] sig_y, in_head;

  nl_fifo #(.W(DW), .DEPTH(IN_DEPTH)) u_in_fifo (
    .clk_i, .rst_ni, .push_i(send_i), .data_i(send_data_i), .pop_i(ld_i),
    .data_o(in_head), .empty_o(in_empty_o), .full_o(in_full_o)
  );

  nl_fifo #(.W(DW), .DEPTH(OUT_DEPTH)) u_out_fifo (
    .clk_i, .rst_ni, .push_i(act_i && act_out_i), .data_i(sig_y), .pop_i(recv_i),
    .data_o(recv_data_o), .empty_o(out_empty_o), .full_o(out_full_o)
  );

  nl_alu #(.DW(DW), .ACCW(ACCW)) u_alu (
    .a_i(w_i), .b_i(src_q[in_idx_i]), .c_i(acc_q), .y_o(mac_y)
  );

  assign acc_sh = acc_q >>> FRAC;
  assign xq = (acc_sh > HI) ? DW'(HI) : (acc_sh < LO) ? DW'(LO) : acc_sh[DW-1:0];

  nl_sigmoid #(.DW(DW)) u_sig (.x_i(xq), .y_o(sig_y));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  acc_q <= '0;
    else if (clr_i || act_i)      acc_q <= '0;
    else if (mac_i)               acc_q <= mac_y;
  end

  always_ff @(posedge clk_i) begin
    if (ld_i) src_q[in_idx_i] <= in_head;
    if (act_i && !act_out_i) dst_q[nrn_idx_i] <= sig_y;
    if (swap_i) src_q <= dst_q;
  end

  AST_SIG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> (sig_y <= DW'(1 << FRAC)));  // R3
  AST_OUT_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && act_out_i) |-> !out_full_o);  // R10
  AST_LOAD_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> !in_empty_o);  // R11
endmodule

// File: rtl/nl_ctrl.sv
module nl_ctrl import nl_pkg::*; #(
  parameter int MAXN  = 8,
  parameter int MAXL  = 3,
  localparam int CW   = $clog2(MAXN + 1),
  localparam int LW   = $clog2(MAXL + 1),
  localparam int IDXW = $clog2(MAXN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [LW-1:0]   cfg_layers_i,
  input  logic [CW-1:0]   cfg_inputs_i,
  input  logic [MAXL*CW-1:0] cfg_neurons_i,
  input  logic            any_in_empty_i,
  input  logic            any_out_full_i,
  input  logic            w_empty_i,
  output logic            ld_o,
  output logic            mac_o,
  output logic            act_o,
  output logic            act_out_o,
  output logic            swap_o,
  output logic            clr_o,
  output logic [IDXW-1:0] in_idx_o,
  output logic [IDXW-1:0] nrn_idx_o,
  output logic            mode_o,
  output logic            done_o
);
  nl_state_e st_q;
  logic [LW-1:0] n_layers_q, layer_q;
  logic [CW-1:0] n_in_q, fan, cur_n;
  logic [CW-1:0] nrn_q [MAXL];
  logic [IDXW-1:0] i_q, j_q;
  logic last_in, last_nrn, last_layer;

  always_comb begin
    fan   = n_in_q;
    cur_n = nrn_q[0];
    for (int k = 1; k < MAXL; k++) begin
      if (layer_q == LW'(k)) begin
        fan   = nrn_q[k-1];
        cur_n = nrn_q[k];
      end
    end
  end

  assign last_in    = (i_q == IDXW'(fan - CW'(1)));
  assign last_nrn   = (j_q == IDXW'(cur_n - CW'(1)));
  assign last_layer = (layer_q == n_layers_q - LW'(1));

  assign ld_o      = (st_q == ST_LOAD) && !any_in_empty_i;
  assign mac_o     = (st_q == ST_MAC) && !w_empty_i;
  assign act_o     = (st_q == ST_ACT) && !(last_layer && any_out_full_i);
  assign act_out_o = last_layer;
  assign swap_o    = (st_q == ST_NEXT);
  assign clr_o     = (st_q == ST_IDLE) && start_i;
  assign in_idx_o  = i_q;
  assign nrn_idx_o = j_q;
  assign mode_o    = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      n_layers_q <= LW'(1);
      n_in_q     <= CW'(1);
      for (int k = 0; k < MAXL; k++) nrn_q[k] <= CW'(1);
      layer_q    <= '0;
      i_q        <= '0;
      j_q        <= '0;
      done_o     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          n_layers_q <= cfg_layers_i;
          n_in_q     <= cfg_inputs_i;
          for (int k = 0; k < MAXL; k++) nrn_q[k] <= cfg_neurons_i[k*CW +: CW];
          layer_q <= '0;
          i_q     <= '0;
          j_q     <= '0;
          done_o  <= 1'b0;
          st_q    <= ST_LOAD;
        end
        ST_LOAD: if (ld_o) begin
          i_q <= last_in ? '0 : i_q + 1'b1;
          if (last_in) st_q <= ST_MAC;
        end
        ST_MAC: if (mac_o) begin
          i_q <= last_in ? '0 : i_q + 1'b1;
          if (last_in) st_q <= ST_ACT;
        end
        ST_ACT: if (act_o) begin
          if (!last_nrn) begin
            j_q  <= j_q + 1'b1;
            st_q <= ST_MAC;
          end else begin
            j_q <= '0;
            if (last_layer) begin
              done_o <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_NEXT;
            end
          end
        end
        ST_NEXT: begin
          layer_q <= layer_q + 1'b1;
          st_q    <= ST_MAC;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mode_o);  // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(mode_o));  // R8
endmodule

// File: rtl/nl_array.sv
module nl_array #(
  parameter int LANES     = 4,
  parameter int DW        = 16,
  parameter int ACCW      = 32,
  parameter int MAXN      = 8,
  parameter int MAXL      = 3,
  parameter int IN_DEPTH  = 8,
  parameter int OUT_DEPTH = 4,
  parameter int W_DEPTH   = 16,
  localparam int CW       = $clog2(MAXN + 1),
  localparam int LW       = $clog2(MAXL + 1),
  localparam int IDXW     = $clog2(MAXN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [LW-1:0]       cfg_layers_i,
  input  logic [CW-1:0]       cfg_inputs_i,
  input  logic [MAXL*CW-1:0]  cfg_neurons_i,
  input  logic                w_push_i,
  input  logic [DW-1:0]       w_data_i,
  output logic                w_full_o,
  input  logic                send_i,
  input  logic [LANES*DW-1:0] send_data_i,
  output logic                send_full_o,
  input  logic                recv_i,
  output logic [LANES*DW-1:0] recv_data_o,
  output logic                recv_valid_o,
  output logic                neural_mode_o,
  output logic                done_o
);
  logic w_empty, w_pop;
  logic [DW-1:0] w_head;
  logic ld, mac, act, act_out, swap, clr;
  logic [IDXW-1:0] in_idx, nrn_idx;
  logic [LANES-1:0] in_empty, in_full, out_empty, out_full;

  nl_fifo #(.W(DW), .DEPTH(W_DEPTH)) u_w_fifo (
    .clk_i, .rst_ni, .push_i(w_push_i), .data_i(w_data_i), .pop_i(w_pop),
    .data_o(w_head), .empty_o(w_empty), .full_o(w_full_o)
  );

  nl_ctrl #(.MAXN(MAXN), .MAXL(MAXL)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .cfg_layers_i, .cfg_inputs_i, .cfg_neurons_i,
    .any_in_empty_i(|in_empty), .any_out_full_i(|out_full), .w_empty_i(w_empty),
    .ld_o(ld), .mac_o(mac), .act_o(act), .act_out_o(act_out), .swap_o(swap),
    .clr_o(clr), .in_idx_o(in_idx), .nrn_idx_o(nrn_idx),
    .mode_o(neural_mode_o), .done_o
  );
  assign w_pop = mac;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    nl_lane #(
      .DW(DW), .ACCW(ACCW), .MAXN(MAXN), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)
    ) u_lane (
      .clk_i, .rst_ni,
      .send_i, .send_data_i(send_data_i[l*DW +: DW]),
      .recv_i, .recv_data_o(recv_data_o[l*DW +: DW]),
      .in_empty_o(in_empty[l]), .in_full_o(in_full[l]),
      .out_empty_o(out_empty[l]), .out_full_o(out_full[l]),
      .ld_i(ld), .mac_i(mac), .act_i(act), .act_out_i(act_out), .swap_i(swap),
      .clr_i(clr), .in_idx_i(in_idx), .nrn_idx_i(nrn_idx), .w_i(w_head)
    );
  end

  assign send_full_o  = |in_full;
  assign recv_valid_o = ~|out_empty;

  AST_MAC_HAS_WEIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac |-> !w_empty);  // R9
  AST_LOCKSTEP_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_empty == '0) || (out_empty == '1));  // R4
  AST_LOCKSTEP_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_empty == '0) || (in_empty == '1));  // R4
  AST_START_ENTERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !neural_mode_o) |=> neural_mode_o);  // R8
endmodule

// File: tb/nl_array_bench.sv
module nl_array_bench;
  localparam int LANES = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] cfg_layers_i = '0;
  logic [3:0] cfg_inputs_i = '0;
  logic [11:0] cfg_neurons_i = '0;
  logic w_push_i = 1'b0;
  logic [DW-1:0] w_data_i = '0;
  logic w_full_o;
  logic send_i = 1'b0;
  logic [LANES*DW-1:0] send_data_i = '0;
  logic send_full_o;
  logic recv_i = 1'b0;
  logic [LANES*DW-1:0] recv_data_o;
  logic recv_valid_o, neural_mode_o, done_o;

  always #4 clk = ~clk;

  nl_array u_nl_array (
    .clk_i(clk), .rst_ni, .start_i, .cfg_layers_i, .cfg_inputs_i, .cfg_neurons_i,
    .w_push_i, .w_data_i, .w_full_o, .send_i, .send_data_i, .send_full_o,
    .recv_i, .recv_data_o, .recv_valid_o, .neural_mode_o, .done_o
  );

  int total = 0, bad = 0;
  int nl, nin;
  int nn [3];
  int inp [LANES][8];
  int exp_out [LANES][8];
  int w_q [$];
  int seed = 7;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rnd(input int span);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 32'h7fff) % (2 * span + 1) - span;
  endfunction

  function automatic int sig_ref(input int x);
    real mid;
    if (x < -2048) return 0;
    if (x > 2047) return 256;
    mid = -8.0 + 0.25 * ((x + 2048) >>> 6) + 0.125;
    return int'($floor(256.0 / (1.0 + $exp(-mid)) + 0.5));
  endfunction

  task automatic build_expect();
    int act [8];
    int nxt [8];
    int wi, fan;
    longint acc;
    longint xq;
    for (int l = 0; l < LANES; l++) begin
      wi = 0;
      fan = nin;
      for (int i = 0; i < nin; i++) act[i] = inp[l][i];
      for (int ly = 0; ly < nl; ly++) begin
        for (int j = 0; j < nn[ly]; j++) begin
          acc = 0;
          for (int i = 0; i < fan; i++) begin
            acc += longint'(w_q[wi]) * longint'(act[i]);
            wi++;
          end
          xq = acc >>> 8;
          if (xq > 32767) xq = 32767;
          if (xq < -32768) xq = -32768;
          nxt[j] = sig_ref(int'(xq));
        end
        for (int j = 0; j < nn[ly]; j++) act[j] = nxt[j];
        fan = nn[ly];
      end
      for (int j = 0; j < nn[nl-1]; j++) exp_out[l][j] = act[j];
    end
  endtask

  task automatic send_inputs();
    for (int i = 0; i < nin; i++) begin
      send_i = 1'b1;
      for (int l = 0; l < LANES; l++) send_data_i[l*DW +: DW] = 16'(inp[l][i]);
      @(negedge clk);
    end
    send_i = 1'b0;
  endtask

  task automatic gen_weights(input int span);
    int cnt, fan;
    w_q.delete();
    fan = nin;
    cnt = 0;
    for (int ly = 0; ly < nl; ly++) begin
      cnt += fan * nn[ly];
      fan = nn[ly];
    end
    for (int k = 0; k < cnt; k++) w_q.push_back(rnd(span));
  endtask

  task automatic run_net(input string req, input int w_delay, input int recv_delay,
                         input bit in_late, input bit poke_start, input bit cfg_poke);
    int wi, got, c, nout;
    build_expect();
    nout = nn[nl-1];
    if (!in_late) begin
      send_inputs();
      if (nin == 8) chk(send_full_o == 1'b1, "R7 send_full", int'(send_full_o), 1);
    end
    cfg_layers_i = 2'(nl);
    cfg_inputs_i = 4'(nin);
    cfg_neurons_i = {4'(nn[2]), 4'(nn[1]), 4'(nn[0])};
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(neural_mode_o && !done_o, "R8 enter", int'(neural_mode_o), 1);
    if (cfg_poke) begin
      cfg_layers_i = 2'd1;
      cfg_inputs_i = 4'd1;
      cfg_neurons_i = 12'h111;
    end
    if (in_late) begin
      repeat (10) @(negedge clk);
      chk(neural_mode_o && !recv_valid_o, "R11 wait inputs", int'(recv_valid_o), 0);
      send_inputs();
    end
    wi = 0; got = 0; c = 0;
    while (!(got == nout && !neural_mode_o) && c < 5000) begin
      w_push_i = 1'b0;
      recv_i = 1'b0;
      start_i = 1'b0;
      if (w_delay > 0 && c == w_delay - 1)
        chk(neural_mode_o && !recv_valid_o, "R9 weight stall", int'(recv_valid_o), 0);
      if (recv_delay > 0 && c == recv_delay - 1)
        chk(neural_mode_o && recv_valid_o, "R10 output stall", int'(neural_mode_o), 1);
      if (poke_start && c == 3) start_i = 1'b1;
      if (c >= w_delay && wi < w_q.size() && !w_full_o) begin
        w_push_i = 1'b1;
        w_data_i = 16'(w_q[wi]);
        wi++;
      end
      if (c >= recv_delay && recv_valid_o && got < nout) begin
        recv_i = 1'b1;
        for (int l = 0; l < LANES; l++)
          chk(int'(recv_data_o[l*DW +: DW]) == exp_out[l][got], req,
              int'(recv_data_o[l*DW +: DW]), exp_out[l][got]);
        got++;
      end
      @(negedge clk);
      c++;
    end
    w_push_i = 1'b0;
    recv_i = 1'b0;
    start_i = 1'b0;
    chk(c < 5000, "R8 completes", c, 5000);
    chk(done_o && !neural_mode_o, "R8 done", int'(done_o), 1);
    repeat (3) @(negedge clk);
    chk(!recv_valid_o && !neural_mode_o, "R8 no extra run", int'(recv_valid_o), 0);
  endtask

  task automatic t_reset();
    chk(!neural_mode_o && !done_o, "R1 mode/done", int'(neural_mode_o), 0);
    chk(!recv_valid_o, "R1 recv_valid", int'(recv_valid_o), 0);
    chk(!w_full_o && !send_full_o, "R1 full flags", int'(w_full_o), 0);
  endtask

  task automatic t_basic();
    nl = 2; nin = 2; nn = '{2, 1, 1};
    for (int l = 0; l < LANES; l++)
      for (int i = 0; i < 8; i++) inp[l][i] = rnd(600);
    gen_weights(400);
    run_net("R4 lanes share weights", 0, 0, 0, 0, 0);
  endtask

  task automatic t_sigmoid();
    int wl [7] = '{0, 2047, 2048, -1, -2049, 300, -700};
    nl = 1; nin = 1; nn = '{1, 1, 1};
    inp[0][0] = 256; inp[1][0] = 512; inp[2][0] = -256; inp[3][0] = 128;
    foreach (wl[k]) begin
      w_q.delete();
      w_q.push_back(wl[k]);
      run_net("R3 sigmoid", 0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_saturate();
    nl = 1; nin = 2; nn = '{1, 1, 1};
    for (int l = 0; l < LANES; l++) begin
      inp[l][0] = (l[0]) ? -30000 : 30000;
      inp[l][1] = 30000;
    end
    w_q.delete();
    w_q.push_back(30000);
    w_q.push_back(30000);
    run_net("R2 saturate", 0, 0, 0, 0, 0);
  endtask

  task automatic t_deep();
    nl = 3; nin = 3; nn = '{4, 3, 2};
    for (int l = 0; l < LANES; l++)
      for (int i = 0; i < 8; i++) inp[l][i] = rnd(500);
    gen_weights(300);
    run_net("R5 hidden feed", 0, 0, 0, 1, 1);
  endtask

  task automatic t_wide();
    nl = 3; nin = 8; nn = '{8, 8, 2};
    for (int l = 0; l < LANES; l++)
      for (int i = 0; i < 8; i++) inp[l][i] = rnd(300);
    gen_weights(120);
    run_net("R6 max topology", 0, 0, 0, 0, 0);
  endtask

  task automatic t_weight_stall();
    nl = 2; nin = 2; nn = '{3, 2, 1};
    for (int l = 0; l < LANES; l++)
      for (int i = 0; i < 8; i++) inp[l][i] = rnd(400);
    gen_weights(300);
    run_net("R9 late weights", 50, 0, 0, 0, 0);
  endtask

  task automatic t_out_stall();
    nl = 1; nin = 3; nn = '{8, 1, 1};
    for (int l = 0; l < LANES; l++)
      for (int i = 0; i < 8; i++) inp[l][i] = rnd(400);
    gen_weights(300);
    run_net("R10 held results", 0, 200, 0, 0, 0);
  endtask

  task automatic t_input_late();
    nl = 2; nin = 4; nn = '{2, 2, 1};
    for (int l = 0; l < LANES; l++)
      for (int i = 0; i < 8; i++) inp[l][i] = rnd(400);
    gen_weights(300);
    run_net("R11 late inputs", 0, 0, 1, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sigmoid();
    t_saturate();
    t_deep();
    t_wide();       // also R7: eight sends fill the input queues
    t_weight_stall();
    t_out_stall();
    t_input_late();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule